// File: doc/BRIEF.md
# First-Fit Contiguous Page Allocator

This block looks after a pool of on-chip queue memory made of 128 pages, each page 16 dwords wide. One bit per page records whether the page is in use. A requester asks for a contiguous span of 1, 2, 4 or 8 pages. The block then scans candidate start pages from page 0 upward, one candidate per clock, and claims the first span whose pages are all free. It answers with the start page, or with an error code when no span fits.

A release request names a start page and a span size and frees those pages in a single cycle. The lowest four pages are held as used from reset onward. Neither an allocation nor a release can ever change them.

Requests use a simple valid/busy handshake. A request is taken on a clock edge where `req_valid` is high and `busy` is low. Every accepted request ends with exactly one `done` pulse that carries the result.

Top module: `page_pool_alloc`

## Requirements
- R1: After reset, `busy` and `done` are low and pages 0 to 3 are marked used; no allocation ever returns a start page below 4.
- R2: A request whose `req_pages` is not 1, 2, 4 or 8 gets a `done` pulse on the edge that accepts it, with `ok`=0 and `err_code`=1 (bad size), and it leaves the page map unchanged.
- R3: An allocation returns the lowest start page at which `req_pages` consecutive pages are all free. The candidate moves up one page at a time, with no alignment to the span size, and all pages of the chosen span become used together.
- R4: The search checks one candidate per clock starting from page 0. A successful allocation at start page s raises `done` s+1 clock edges after the accepting edge.
- R5: When the candidate start plus the span size would pass page 128, the allocation ends with `ok`=0 and `err_code`=2 (no space), and the page map is unchanged.
- R6: A release with a legal size and a span that lies inside pages 4 to 127 frees exactly that span. It gets `done` on the accepting edge with `ok`=1, `err_code`=0 and `start_page` equal to the released start.
- R7: A release whose span touches pages 0 to 3 or runs past page 127 is ignored. It gets `done` with `ok`=0 and `err_code`=3 (range).
- R8: `busy` is high from the accepting edge of an allocation until the edge that raises `done`. A `req_valid` seen while `busy` is high is ignored and produces no `done`.
- R9: `done` is a single-cycle pulse per accepted request. With it, `ok`=1 exactly when `err_code`=0, and on a successful allocation `start_page` holds the claimed start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_pages | input | 4 | Span size in pages (legal: 1, 2, 4, 8) |
| req_start | input | 7 | Start page of a release |
| busy | output | 1 | Allocation search in progress |
| done | output | 1 | One-cycle result pulse |
| ok | output | 1 | Request succeeded |
| err_code | output | 2 | 0 none, 1 bad size, 2 no space, 3 range |
| start_page | output | 7 | Start page of the claimed or released span |

## Verification
The assertions assume that reset is held for at least one clock edge before any request. They also assume that a release only names spans the caller owns; the block does not track ownership, so a stray release simply frees pages. The stimulus always waits for the previous result before it issues the next request, except for one deliberate pulse of `req_valid` during a running search. It releases only spans it has worked out from its own page model, plus the deliberately illegal range and size cases.

// File: rtl/page_pool_pkg.sv
// Shared types for the page pool allocator.
package page_pool_pkg;
    // Result codes returned with the done pulse.
    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIZE  = 2'd1,
        ERR_FULL  = 2'd2,
        ERR_RANGE = 2'd3
    } pool_err_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } pool_state_e;

    localparam logic OP_ALLOC = 1'b0;
    localparam logic OP_FREE  = 1'b1;
endpackage

// File: rtl/span_size_decode.sv
// Decodes a page count into a legal/illegal flag and a span length.
// The only legal counts are powers of two, from 1 up to 2**MAX_LOG.
// Assumes: PW can hold 2**MAX_LOG.
module span_size_decode #(
    parameter int MAX_LOG = 3,
    parameter int PW      = MAX_LOG + 1,
    parameter int SW      = 8
) (
    input  logic [PW-1:0] pages,
    output logic          legal,
    output logic [SW-1:0] len
);
    logic [MAX_LOG:0] hit;

    // One comparator for each legal power-of-two size.
    for (genvar k = 0; k <= MAX_LOG; k++) begin : g_hit
        localparam logic [PW-1:0] SIZE_K = PW'(1 << k);
        assign hit[k] = (pages == SIZE_K);
    end

    // Merge the size hits into the outputs.
    always_comb begin
        legal = |hit;
        len   = SW'(pages);
    end
endmodule

// File: rtl/span_mask.sv
// Builds a one-hot-run mask over the pool covering [base, base+len).
// Also reports whether the span ends inside the pool.
// Assumes: SW is wide enough for base+len to reach past NUM_PAGES.
module span_mask #(
    parameter int NUM_PAGES = 128,
    parameter int SW        = 8
) (
    input  logic [SW-1:0]        base,
    input  logic [SW-1:0]        len,
    output logic [NUM_PAGES-1:0] mask,
    output logic                 fits
);
    logic [SW:0] span_end;

    // End of span, one bit wider so it cannot wrap.
    always_comb begin
        span_end = {1'b0, base} + {1'b0, len};
        fits     = (span_end <= (SW+1)'(NUM_PAGES));
    end

    // Range test for each page.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_bit
        localparam logic [SW:0] PIDX = (SW+1)'(p);
        assign mask[p] = (PIDX >= {1'b0, base}) && (PIDX < span_end);
    end
endmodule

// File: rtl/page_bitmap.sv
// Occupancy map, one bit per page. At reset the lowest RESERVED
// pages read as used. Set and clear masks come from the controller.
// Assumes: set and clear never target the same bit in one cycle.
module page_bitmap #(
    parameter int NUM_PAGES = 128,
    parameter int RESERVED  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic                 clr_en,
    input  logic [NUM_PAGES-1:0] upd_mask,
    output logic [NUM_PAGES-1:0] used
);
    localparam logic [NUM_PAGES-1:0] RESET_MAP = NUM_PAGES'((1 << RESERVED) - 1);

    // Map update: claim or free the pages under the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      used <= RESET_MAP;
        else if (set_en) used <= used | upd_mask;
        else if (clr_en) used <= used & ~upd_mask;
    end
endmodule

// File: rtl/page_pool_alloc.sv
// First-fit contiguous page allocator. An allocation scans candidate
// starts from page 0, one per clock, and claims the first all-free
// span. A release frees a span in one cycle. The reserved low pages
// are never touched.
// Assumes: the caller releases only spans it owns.
module page_pool_alloc
    import page_pool_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int RESERVED  = 4,
    parameter int MAX_LOG   = 3,
    localparam int AW = $clog2(NUM_PAGES),
    localparam int PW = MAX_LOG + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [PW-1:0] req_pages,
    input  logic [AW-1:0] req_start,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic [1:0]    err_code,
    output logic [AW-1:0] start_page
);
    localparam int SW = AW + 1;
    localparam logic [AW-1:0] RES_L = AW'(RESERVED);

    pool_state_e          state;
    logic [SW-1:0]        cand;
    logic [SW-1:0]        len_q;
    logic [SW-1:0]        req_len;
    logic                 req_legal;
    logic [SW-1:0]        mask_base;
    logic [SW-1:0]        mask_len;
    logic [NUM_PAGES-1:0] span;
    logic                 span_fits;
    logic [NUM_PAGES-1:0] used_map;
    logic                 conflict;
    logic                 accept;
    logic                 set_en;
    logic                 clr_en;

    span_size_decode #(.MAX_LOG(MAX_LOG), .PW(PW), .SW(SW)) u_size (
        .pages (req_pages),
        .legal (req_legal),
        .len   (req_len)
    );

    // One mask generator, shared by the search and the release paths.
    always_comb begin
        if (state == ST_SEARCH) begin
            mask_base = cand;
            mask_len  = len_q;
        end else begin
            mask_base = {1'b0, req_start};
            mask_len  = req_len;
        end
    end

    span_mask #(.NUM_PAGES(NUM_PAGES), .SW(SW)) u_mask (
        .base (mask_base),
        .len  (mask_len),
        .mask (span),
        .fits (span_fits)
    );

    page_bitmap #(.NUM_PAGES(NUM_PAGES), .RESERVED(RESERVED)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .clr_en   (clr_en),
        .upd_mask (span),
        .used     (used_map)
    );

    // Decide accept, conflict and the map write enables.
    always_comb begin
        accept   = req_valid && (state == ST_IDLE);
        conflict = |(used_map & span);
        set_en   = (state == ST_SEARCH) && span_fits && !conflict;
        clr_en   = accept && req_legal && (req_op == OP_FREE)
                   && span_fits && (req_start >= RES_L);
        busy     = (state == ST_SEARCH);
    end

    // Controller: take a request, step the search, post the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cand       <= '0;
            len_q      <= '0;
            done       <= 1'b0;
            ok         <= 1'b0;
            err_code   <= ERR_NONE;
            start_page <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!req_legal) begin
                            done     <= 1'b1;
                            ok       <= 1'b0;
                            err_code <= ERR_SIZE;
                        end else if (req_op == OP_ALLOC) begin
                            state <= ST_SEARCH;
                            cand  <= '0;
                            len_q <= req_len;
                        end else if (clr_en) begin
                            done       <= 1'b1;
                            ok         <= 1'b1;
                            err_code   <= ERR_NONE;
                            start_page <= req_start;
                        end else begin
                            done     <= 1'b1;
                            ok       <= 1'b0;
                            err_code <= ERR_RANGE;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (!span_fits) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        ok       <= 1'b0;
                        err_code <= ERR_FULL;
                    end else if (!conflict) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        ok         <= 1'b1;
                        err_code   <= ERR_NONE;
                        start_page <= cand[AW-1:0];
                    end else begin
                        cand <= cand + SW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/page_pool_alloc_chk.sv
// Protocol and state checks for the page pool allocator.
// Assumes: it is bound to page_pool_alloc and sees its page map.
module page_pool_alloc_chk #(
    parameter int NUM_PAGES = 128,
    parameter int RESERVED  = 4,
    parameter int AW        = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 ok,
    input logic [1:0]           err_code,
    input logic [AW-1:0]        start_page,
    input logic [NUM_PAGES-1:0] used_map
);
    localparam int CW = $clog2(NUM_PAGES + 4) + 1;
    logic [CW-1:0] search_len;

    // Counts the length of the current search.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) search_len <= '0;
        else                 search_len <= search_len + CW'(1);
    end

    assert_reserved_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        &used_map[RESERVED-1:0]);

    assert_alloc_above_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && $past(busy)) |-> (start_page >= AW'(RESERVED)));

    assert_search_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        search_len <= CW'(NUM_PAGES + 2));

    assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_ok_matches_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok == (err_code == 2'd0)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |=> !done);
endmodule

bind page_pool_alloc page_pool_alloc_chk #(
    .NUM_PAGES (NUM_PAGES),
    .RESERVED  (RESERVED),
    .AW        (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .err_code   (err_code),
    .start_page (start_page),
    .used_map   (used_map)
);

// File: tb/page_pool_alloc_test.sv
// Scoreboard bench: the driver works out each expected result from its
// own page model and queues it; the monitor compares on every done.
module page_pool_alloc_test;
    localparam int N   = 128;
    localparam int RES = 4;
    localparam int AW  = 7;
    localparam int PW  = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_op;
    logic [PW-1:0] req_pages;
    logic [AW-1:0] req_start;
    logic          busy, done, ok;
    logic [1:0]    err_code;
    logic [AW-1:0] start_page;

    always #4 clk = ~clk;

    page_pool_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pages(req_pages), .req_start(req_start), .busy(busy),
        .done(done), .ok(ok), .err_code(err_code), .start_page(start_page)
    );

    typedef struct {
        logic          ok;
        logic [1:0]    err;
        logic [AW-1:0] start;
        int            due;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    bit          reported = 0;
    logic [N-1:0] model;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit cond, string tag, string what, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    endtask

    // Monitor: pop and compare on every done pulse.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (sb.size() == 0) begin
                check(0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ok == e.ok, e.tag, "ok", int'(ok), int'(e.ok));
                check(err_code == e.err, e.tag, "err_code", int'(err_code), int'(e.err));
                if (e.ok)
                    check(start_page == e.start, e.tag, "start_page",
                          int'(start_page), int'(e.start));
                check(cyc == e.due, e.tag, "done cycle", cyc, e.due);
            end
        end
    end

    // Driver: model the request, queue the expectation, drive one cycle.
    task automatic issue(bit op, int pages, int start, string tag, bit inject = 0);
        exp_t e;
        int   lat;
        bit   legal;
        while (busy) @(negedge clk);
        legal = (pages == 1 || pages == 2 || pages == 4 || pages == 8);
        e.ok = 0; e.err = 2'd0; e.start = '0; e.tag = tag; lat = 0;
        if (!legal) begin
            e.err = 2'd1;
        end else if (op == 1'b0) begin
            bit found = 0;
            for (int s = 0; s + pages <= N; s++) begin
                bit free = 1;
                for (int p = s; p < s + pages; p++) if (model[p]) free = 0;
                if (free) begin
                    found = 1; e.ok = 1; e.start = AW'(s); lat = s + 1;
                    for (int p = s; p < s + pages; p++) model[p] = 1'b1;
                    break;
                end
            end
            if (!found) begin
                e.err = 2'd2; lat = N - pages + 2;
            end
        end else begin
            if (start < RES || start + pages > N) begin
                e.err = 2'd3;
            end else begin
                e.ok = 1; e.start = AW'(start);
                for (int p = start; p < start + pages; p++) model[p] = 1'b0;
            end
        end
        e.due = cyc + 1 + lat;
        sb.push_back(e);
        req_valid = 1'b1; req_op = op;
        req_pages = PW'(pages); req_start = AW'(start);
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            // A release pulsed during a search must be ignored.
            check(busy == 1'b1, "R8", "busy during search", int'(busy), 1);
            req_valid = 1'b1; req_op = 1'b1; req_pages = PW'(1); req_start = AW'(RES);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R8", "watchdog expired", 1, 0);
        report();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0;
        req_pages = '0; req_start = '0;
        model = N'((1 << RES) - 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);

        // First fit above the reserved pages, unaligned spans.
        issue(1'b0, 1, 0, "R1");
        issue(1'b0, 2, 0, "R3");
        issue(1'b0, 4, 0, "R3");
        issue(1'b0, 8, 0, "R4");
        // Free a hole and refill it first fit.
        issue(1'b1, 2, 5, "R6");
        issue(1'b0, 1, 0, "R3");
        issue(1'b0, 2, 0, "R3");
        issue(1'b0, 1, 0, "R3");
        // Illegal sizes on both request kinds.
        issue(1'b0, 3, 0, "R2");
        issue(1'b0, 0, 0, "R2");
        issue(1'b1, 9, 20, "R2");
        issue(1'b0, 15, 0, "R2");
        // Releases touching reserved pages or beyond the pool.
        issue(1'b1, 1, 2, "R7");
        issue(1'b1, 8, 125, "R7");
        issue(1'b1, 2, 126, "R6");
        issue(1'b0, 1, 0, "R7");
        // Request during a search is ignored.
        issue(1'b0, 4, 0, "R8", 1'b1);
        issue(1'b0, 1, 0, "R8");
        // Fill the pool until there is no space.
        for (int i = 0; i < 16; i++) issue(1'b0, 8, 0, "R5");
        issue(1'b0, 8, 0, "R5");
        issue(1'b0, 1, 0, "R5");
        // Free one span and claim it back.
        issue(1'b1, 8, 60, "R6");
        issue(1'b0, 8, 0, "R9");
        issue(1'b0, 2, 0, "R9");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9", "pending results", sb.size(), 0);
        report();
    end
endmodule